// File: doc/BRIEF.md
# General-Purpose Pin Bank Controller with Bit Set/Clear Access

This block manages a bank of up to 32 general-purpose pins. Each pin is either handed to a peripheral function or owned by the controller. When the controller owns a pin, it drives the pad's output value and output enable from its own registers. Every pin input passes through a two-flop synchronizer. An optional glitch filter can then be enabled per pin, and the resulting level is delivered to the peripheral side. A transition on that level, in either direction, latches a per-pin change flag. The flags, gated by a per-pin mask, are ORed into one interrupt line.

Software uses a small register bus. Each writable control register has three word addresses: one sets bits, one clears bits and one reads the value. Any bit can therefore be changed without a read-modify-write sequence. The change-flag register clears itself when it is read.

Top module: `pinbank_ctrl`

## Requirements
- R1: After reset every pin is controller-owned with its driver off: the owner register reads all ones, the driver-enable, output-value, filter-enable and mask registers read zero, the change register reads zero, pad_oe is zero and irq is low.
- R2: The word address is {group[2:0], op[1:0]}. The groups are owner 0, driver enable 1, output value 2, filter enable 3, mask 4 and status 5. Writing with op 0 sets each register bit whose write-data bit is 1. Bits written as 0 keep their value.
- R3: Writing with op 1 clears each register bit whose write-data bit is 1. Bits written as 0 keep their value.
- R4: In groups 0 to 4, op 2 returns the register value on rdata in the same cycle, without waiting for a clock edge. Writes to op 2, to op 3, to group 5 or to groups 6 and 7 change no state. Reads of an unused address return zero.
- R5: When a pin's owner bit is 1, pad_out and pad_oe come from the output-value and driver-enable registers. When it is 0, they come from periph_out and periph_oe.
- R6: When filtering is off, a pin_in level sampled at clock edge n appears on periph_in, and at status address {5,0}, after edge n+2.
- R7: When filtering is on, periph_in takes a new synchronized level only after two consecutive samples agree. A pulse lasting one clock never reaches periph_in.
- R8: Any change of periph_in, rising or falling, sets that pin's bit in the change register (status address {5,1}) one clock later.
- R9: Reading the change register with rd_en high returns its value and clears it at the next edge. A change that arrives in the same cycle as the read stays flagged.
- R10: irq is high exactly when some pin has both its change bit and its mask bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 5 | Register word address {group, op} |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; clears the change register when it is addressed |
| wdata | input | NPIN | Write data |
| rdata | output | NPIN | Combinational read data |
| pin_in | input | NPIN | Asynchronous pad input levels |
| periph_out | input | NPIN | Peripheral output values |
| periph_oe | input | NPIN | Peripheral output enables |
| pad_out | output | NPIN | Pad output values |
| pad_oe | output | NPIN | Pad output enables |
| periph_in | output | NPIN | Synchronized, optionally filtered pin levels |
| irq | output | 1 | Combined change interrupt |

## Verification
The hardest situation to bring about is a change-register read that lands in the same clock as a new transition, since the clear and the new event then race. Equally hard is a filter-enabled pin whose input flips for exactly one sample. The bench steers into both with directed sequences timed from the known three-edge input latency. It then runs a long stretch of random register traffic interleaved with random pin toggles, so that reads, masks, filter changes and transitions overlap in every order. A behavioural model, driven by a queue of sampled input history, tracks every output on every cycle.

// File: rtl/pinbank_pkg.sv
// Shared constants for the pin bank controller: address field layout,
// register group codes and operation codes.
package pinbank_pkg;
    localparam int ADDR_W  = 5;
    localparam int NUM_GRP = 5;

    typedef enum logic [2:0] {
        GRP_OWN  = 3'd0,
        GRP_DRV  = 3'd1,
        GRP_OUT  = 3'd2,
        GRP_FLT  = 3'd3,
        GRP_MSK  = 3'd4,
        GRP_STAT = 3'd5
    } grp_e;

    localparam logic [1:0] OP_SET = 2'd0;
    localparam logic [1:0] OP_CLR = 2'd1;
    localparam logic [1:0] OP_VAL = 2'd2;

    localparam logic [1:0] STAT_LVL = 2'd0;
    localparam logic [1:0] STAT_CHG = 2'd1;
endpackage

// File: rtl/pinbank_sclr.sv
// One control register with bit-set and bit-clear strobes.
// Assumes the set and clear strobes are never both high (distinct addresses).
module pinbank_sclr #(
    parameter int          W   = 32,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    // Update only the bits selected by ones in wdata.
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= RST;
        else if (set_stb) q <= q | wdata;
        else if (clr_stb) q <= q & ~wdata;
    end
endmodule

// File: rtl/pinbank_infilt.sv
// Input conditioning: two-flop synchronizer, then a per-pin selectable
// filter that accepts a level once two consecutive samples agree.
// Assumes pin_in is asynchronous to clk.
module pinbank_infilt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    input  logic [W-1:0] flt_en,
    output logic [W-1:0] samp,
    output logic [W-1:0] prev_samp,
    output logic [W-1:0] lvl
);
    logic [W-1:0] meta;

    // Synchronizer chain plus one history stage for the filter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta      <= '0;
            samp      <= '0;
            prev_samp <= '0;
        end else begin
            meta      <= pin_in;
            samp      <= meta;
            prev_samp <= samp;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_pin
        // Per-pin level: pass-through or agreement-gated.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lvl[i] <= 1'b0;
            else if (!flt_en[i])
                lvl[i] <= samp[i];
            else if (samp[i] == prev_samp[i])
                lvl[i] <= samp[i];
        end
    end
endmodule

// File: rtl/pinbank_chgdet.sv
// Edge detection on the conditioned levels, sticky change flags that clear
// on read, and the masked interrupt. A new edge wins over a clear.
module pinbank_chgdet #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic         rd_clr,
    input  logic [W-1:0] msk,
    output logic [W-1:0] prev_lvl,
    output logic [W-1:0] chg,
    output logic         irq
);
    // Previous level and sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_lvl <= '0;
            chg      <= '0;
        end else begin
            prev_lvl <= lvl;
            chg      <= (rd_clr ? '0 : chg) | (lvl ^ prev_lvl);
        end
    end

    // Combine enabled flags into one request.
    always_comb irq = |(chg & msk);
endmodule

// File: rtl/pinbank_ctrl.sv
// Top of the pin bank controller: register decode, five set/clear/value
// registers, pad ownership mux and read mux. Read data is combinational.
module pinbank_ctrl
    import pinbank_pkg::*;
#(
    parameter int NPIN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [NPIN-1:0]   wdata,
    output logic [NPIN-1:0]   rdata,
    input  logic [NPIN-1:0]   pin_in,
    input  logic [NPIN-1:0]   periph_out,
    input  logic [NPIN-1:0]   periph_oe,
    output logic [NPIN-1:0]   pad_out,
    output logic [NPIN-1:0]   pad_oe,
    output logic [NPIN-1:0]   periph_in,
    output logic              irq
);
    logic [2:0]      grp;
    logic [1:0]      op;
    logic [NPIN-1:0] grp_q [NUM_GRP];
    logic [NPIN-1:0] samp, prev_samp, lvl, prev_lvl, chg;
    logic            rd_clr;

    assign grp = addr[ADDR_W-1:2];
    assign op  = addr[1:0];

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_reg
        localparam logic [NPIN-1:0] RSTV = (g == int'(GRP_OWN)) ? '1 : '0;
        pinbank_sclr #(.W(NPIN), .RST(RSTV)) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_stb (wr_en && grp == 3'(g) && op == OP_SET),
            .clr_stb (wr_en && grp == 3'(g) && op == OP_CLR),
            .wdata   (wdata),
            .q       (grp_q[g])
        );
    end

    pinbank_infilt #(.W(NPIN)) u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .flt_en    (grp_q[GRP_FLT]),
        .samp      (samp),
        .prev_samp (prev_samp),
        .lvl       (lvl)
    );

    assign rd_clr = rd_en && grp == GRP_STAT && op == STAT_CHG;

    pinbank_chgdet #(.W(NPIN)) u_chg (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (lvl),
        .rd_clr   (rd_clr),
        .msk      (grp_q[GRP_MSK]),
        .prev_lvl (prev_lvl),
        .chg      (chg),
        .irq      (irq)
    );

    // Ownership mux: controller registers or peripheral signals per pin.
    always_comb begin
        pad_out = (grp_q[GRP_OWN] & grp_q[GRP_OUT]) | (~grp_q[GRP_OWN] & periph_out);
        pad_oe  = (grp_q[GRP_OWN] & grp_q[GRP_DRV]) | (~grp_q[GRP_OWN] & periph_oe);
    end

    assign periph_in = lvl;

    // Read mux over register values and status words.
    always_comb begin
        rdata = '0;
        unique case (grp)
            GRP_OWN:  if (op == OP_VAL) rdata = grp_q[GRP_OWN];
            GRP_DRV:  if (op == OP_VAL) rdata = grp_q[GRP_DRV];
            GRP_OUT:  if (op == OP_VAL) rdata = grp_q[GRP_OUT];
            GRP_FLT:  if (op == OP_VAL) rdata = grp_q[GRP_FLT];
            GRP_MSK:  if (op == OP_VAL) rdata = grp_q[GRP_MSK];
            GRP_STAT: begin
                if (op == STAT_LVL)      rdata = lvl;
                else if (op == STAT_CHG) rdata = chg;
            end
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/pinbank_ctrl_chk.sv
// Assertion checker for pinbank_ctrl, attached through bind.
module pinbank_ctrl_chk
    import pinbank_pkg::*;
#(
    parameter int NPIN = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [NPIN-1:0]   wdata,
    input logic [NPIN-1:0]   out_q,
    input logic [NPIN-1:0]   msk_q,
    input logic [NPIN-1:0]   flt_q,
    input logic [NPIN-1:0]   samp,
    input logic [NPIN-1:0]   prev_samp,
    input logic [NPIN-1:0]   lvl,
    input logic [NPIN-1:0]   prev_lvl,
    input logic [NPIN-1:0]   chg,
    input logic              irq
);
    localparam logic [ADDR_W-1:0] A_OUT_SET = {GRP_OUT, OP_SET};
    localparam logic [ADDR_W-1:0] A_OUT_CLR = {GRP_OUT, OP_CLR};
    localparam logic [ADDR_W-1:0] A_CHG     = {GRP_STAT, STAT_CHG};

    p_set_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_OUT_SET) |=> ((out_q & $past(wdata)) == $past(wdata)));

    p_clr_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_OUT_CLR) |=> ((out_q & $past(wdata)) == '0));

    p_filter_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((lvl ^ $past(lvl)) & $past(flt_q & (samp ^ prev_samp))) == '0));

    p_edge_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((lvl ^ prev_lvl) != '0) |=> ((chg & $past(lvl ^ prev_lvl)) == $past(lvl ^ prev_lvl)));

    p_read_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_CHG) |=> ((chg & ~$past(lvl ^ prev_lvl)) == '0));

    p_mask_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (msk_q == '0) |-> !irq);
endmodule

bind pinbank_ctrl pinbank_ctrl_chk #(.NPIN(NPIN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .wdata     (wdata),
    .out_q     (grp_q[2]),
    .msk_q     (grp_q[4]),
    .flt_q     (grp_q[3]),
    .samp      (samp),
    .prev_samp (prev_samp),
    .lvl       (lvl),
    .prev_lvl  (prev_lvl),
    .chg       (chg),
    .irq       (irq)
);

// File: tb/pinbank_ctrl_test.sv
module pinbank_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    addr = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [N-1:0]  wdata = '0;
    logic [N-1:0]  rdata;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  periph_out = '0;
    logic [N-1:0]  periph_oe = '0;
    logic [N-1:0]  pad_out, pad_oe, periph_in;
    logic          irq;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 0;

    pinbank_ctrl #(.NPIN(N)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .periph_out(periph_out),
        .periph_oe(periph_oe), .pad_out(pad_out), .pad_oe(pad_oe),
        .periph_in(periph_in), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference state: five registers, history queue of samples.
    logic [N-1:0] m_reg [5];
    logic [N-1:0] m_lvl, m_prev, m_chg;
    logic [N-1:0] hist [$];

    function automatic logic [N-1:0] model_read(logic [4:0] a);
        int g = int'(a[4:2]);
        if (g < 5 && a[1:0] == 2'd2) return m_reg[g];
        if (a == 5'b10100) return m_lvl;
        if (a == 5'b10101) return m_chg;
        return '0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_reg[0] = '1;
            for (int g = 1; g < 5; g++) m_reg[g] = '0;
            m_lvl = '0; m_prev = '0; m_chg = '0;
            hist = '{'0, '0, '0, '0};
        end else begin
            logic [N-1:0] nl;
            hist.push_front(pin_in);
            void'(hist.pop_back());
            for (int i = 0; i < N; i++) begin
                if (!m_reg[3][i])                  nl[i] = hist[2][i];
                else if (hist[2][i] == hist[3][i]) nl[i] = hist[2][i];
                else                               nl[i] = m_lvl[i];
            end
            m_chg = ((rd_en && addr == 5'b10101) ? '0 : m_chg) | (m_lvl ^ m_prev);
            m_prev = m_lvl;
            m_lvl = nl;
            if (wr_en && addr[4:2] < 3'd5) begin
                if (addr[1:0] == 2'd0) m_reg[addr[4:2]] = m_reg[addr[4:2]] | wdata;
                if (addr[1:0] == 2'd1) m_reg[addr[4:2]] = m_reg[addr[4:2]] & ~wdata;
            end
        end
    end

    task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at t=%0t", tag, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R5 pad_out", pad_out, (m_reg[0] & m_reg[2]) | (~m_reg[0] & periph_out));
            check("R5 pad_oe", pad_oe, (m_reg[0] & m_reg[1]) | (~m_reg[0] & periph_oe));
            check("R6 R7 periph_in", periph_in, m_lvl);
            check("R10 irq", N'(irq), N'(|(m_chg & m_reg[4])));
            check("R2 R3 R4 R8 R9 rdata", rdata, model_read(addr));
        end
    end

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic bus(logic [4:0] a, logic w, logic r, logic [N-1:0] d);
        addr = a; wr_en = w; rd_en = r; wdata = d;
        step();
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);
        // R1: reset values seen through the ports
        addr = 5'b00010; #1; check("R1 owner reset", rdata, '1);
        addr = 5'b00110; #1; check("R1 drive reset", rdata, '0);
        addr = 5'b10101; #1; check("R1 change reset", rdata, '0);
        check("R1 pad_oe reset", pad_oe, '0);
        check("R1 irq reset", N'(irq), '0);
        step();

        // R2/R3: set, clear, zero writes, writes to value address
        bus(5'b01000, 1, 0, 32'hA5A5_00FF);
        bus(5'b00100, 1, 0, 32'hFFFF_0000);
        bus(5'b01000, 1, 0, 32'h0);
        bus(5'b01001, 1, 0, 32'h0000_000F);
        addr = 5'b01010; #1; check("R2 R3 out value", rdata, 32'hA5A5_00F0);
        bus(5'b01010, 1, 0, 32'hFFFF_FFFF);
        bus(5'b10100, 1, 0, 32'hFFFF_FFFF);
        bus(5'b11100, 1, 0, 32'hFFFF_FFFF);
        addr = 5'b01010; #1; check("R4 value write ignored", rdata, 32'hA5A5_00F0);
        addr = 5'b11000; #1; check("R4 unused address", rdata, '0);

        // R5: hand low half to the peripheral
        periph_out = 32'h1234_5678; periph_oe = 32'h0F0F_0F0F;
        bus(5'b00001, 1, 0, 32'h0000_FFFF);
        check("R5 pad_out mix", pad_out, 32'hA5A5_5678);
        check("R5 pad_oe mix", pad_oe, 32'hFFFF_0F0F);

        // R6: unfiltered latency; R10 with mask enabled
        bus(5'b10000, 1, 0, 32'h0000_0001);
        pin_in = 32'h0000_0001;
        step(2);
        check("R6 not yet", periph_in & 32'h1, 32'h0);
        step();
        check("R6 arrived", periph_in & 32'h1, 32'h1);
        step();
        check("R8 rise flag", N'(irq), 1);
        bus(5'b10101, 0, 1, '0);
        check("R9 cleared", N'(irq), 0);

        // R7: one-clock pulse on filtered bits 4..7, unfiltered 8..11
        bus(5'b01100, 1, 0, 32'h0000_00F0);
        pin_in = 32'h0000_0FF1;
        step();
        pin_in = 32'h0000_0001;
        step(6);
        check("R7 pulse rejected", periph_in & 32'h0000_00F0, '0);
        addr = 5'b10101; #1; check("R8 unfiltered pulse flagged", rdata & 32'h0000_0F00, 32'h0000_0F00);
        bus(5'b10101, 0, 1, '0);

        // R9: read lands in same cycle as a new edge
        pin_in = 32'h0000_0000;
        step(3);
        bus(5'b10101, 0, 1, '0);
        addr = 5'b10101; #1; check("R9 edge kept", rdata & 32'h1, 32'h1);
        step(2);

        // Random traffic compared cycle by cycle
        for (int k = 0; k < 3000; k++) begin
            logic [4:0] a;
            a = 5'($urandom_range(0, 23));
            if ($urandom_range(0, 3) == 0) pin_in = pin_in ^ (32'h1 << $urandom_range(0, 31));
            if ($urandom_range(0, 7) == 0) pin_in = $urandom;
            if ($urandom_range(0, 15) == 0) periph_out = $urandom;
            bus(a, ($urandom_range(0, 2) == 0), ($urandom_range(0, 1) == 0), $urandom);
        end
        done = 1;
        summary();
    end
endmodule